// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block watches an Ethernet frame byte by byte as it leaves a receive datapath and, once the frame has ended, issues a status word. The word describes the frame's header and its tail. It picks up the two-byte length/type field and the two bytes that follow it. From these it flags MAC control frames, PAUSE requests, control frames with an unknown opcode, and VLAN-tagged frames. It also reports a length/type value that exceeds a configured maximum, bits left over after the last whole byte, and frames too short to hold a complete header.

The range flag compares the length/type field with the configured maximum and does not first decide whether the field holds a length or an EtherType. Ordinary EtherTypes such as 0x0800 or 0x0806 therefore raise it. The flag is informational only. It never marks the frame as faulty and never changes any other flag.

A frame opens with a byte that carries `sof_i` and closes with a byte that carries `eof_i`. Both strobes may sit on the same byte. The datapath may leave idle cycles between bytes. The status word and its strobe appear on the cycle after the closing byte.

Top module: `rx_frame_classifier`

## Requirements
- R1: `status_valid_o` is high for exactly one cycle, the cycle after an accepted byte that carries `eof_i`, and at no other time.
- R2: Status bit 3 (VLAN) is set when the length/type field equals 0x8100. The field is taken from frame bytes 12 (high byte) and 13 (low byte), counting from 0.
- R3: Status bit 4 (range) is set when the length/type field, read as an unsigned number, is greater than `max_len_i`. No type/length decision is made, so 0x0800 sets it under a 1536 limit.
- R4: The range flag has no effect on the frame-fault bit (bit 6) or on any other bit. A frame that differs only in the range result yields an identical word apart from bit 4.
- R5: Status bit 0 (control) is set when the length/type field equals 0x8808.
- R6: Status bit 1 (PAUSE) is set only for a control frame whose opcode, in frame bytes 14 (high) and 15 (low), equals 0x0001.
- R7: Status bit 2 (unsupported opcode) is set for a control frame that does not qualify for bit 1. This includes a control frame that ends before its opcode is complete.
- R8: Status bit 5 (dribble) is set when `extra_bits_i` is non-zero on the closing byte. Those leftover bits are not forwarded anywhere.
- R9: Status bit 6 (short header) is set when the frame has fewer than 14 bytes. Bits 0, 3 and 4 are then clear.
- R10: `sof_i` restarts classification and discards any partial frame, so no flag carries over from earlier bytes. Bytes that arrive while no frame is open are ignored, even if they carry `eof_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_valid_i | input | 1 | A byte is present on `data_i` |
| data_i | input | 8 | Frame byte, first byte on the wire first |
| sof_i | input | 1 | The present byte opens a frame |
| eof_i | input | 1 | The present byte closes the frame |
| extra_bits_i | input | XB_W | Bits received after the last whole byte, sampled with `eof_i` |
| max_len_i | input | LEN_W | Limit used by the range check |
| status_o | output | 7 | Status word: bit0 control, bit1 PAUSE, bit2 unsupported opcode, bit3 VLAN, bit4 range, bit5 dribble, bit6 short header |
| status_valid_o | output | 1 | One-cycle strobe marking `status_o` |

## Verification
The bench builds the block with its default parameters: field offset 12, 16-bit length/type and opcode, and a 3-bit leftover count. This places the VLAN, control and PAUSE codes and all 0 to 7 leftover-bit counts within reach. It drives `max_len_i` both at 1536 and at small limits, so the range flag shows up on short length values as well as on EtherTypes. Frame lengths from 1 to 40 bytes cover frames that stop before, inside and after the header and opcode fields.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef struct packed {
    logic short_hdr;  // bit 6
    logic dribble;    // bit 5
    logic len_range;  // bit 4
    logic vlan;       // bit 3
    logic unsup_op;   // bit 2
    logic pause;      // bit 1
    logic ctrl;       // bit 0
  } rfc_status_t;

  localparam int unsigned STATUS_W = $bits(rfc_status_t);
endpackage

// File: rtl/rfc_field_capture.sv
module rfc_field_capture #(
  parameter int unsigned LT_OFFSET = 12,
  parameter int unsigned FIELD_W   = 16,
  parameter int unsigned CNT_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_valid_i,
  input  logic [7:0]         data_i,
  input  logic               sof_i,
  input  logic               eof_i,
  output logic               accept_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   cnt_nxt_o,
  output logic [FIELD_W-1:0] lt_nxt_o,
  output logic [FIELD_W-1:0] op_nxt_o
);
  localparam int unsigned FB     = FIELD_W / 8;
  localparam int unsigned OP_OFF = LT_OFFSET + FB;
  localparam int unsigned SAT    = OP_OFF + FB;

  logic               in_frame_q;
  logic [CNT_W-1:0]   cnt_q, cnt_base, cnt_nxt;
  logic [FIELD_W-1:0] lt_q, lt_base, lt_nxt;
  logic [FIELD_W-1:0] op_q, op_base, op_nxt;

  assign accept_o = data_valid_i & (sof_i | in_frame_q);
  assign done_o   = accept_o & eof_i;

  // restart clears captured state on the opening byte
  assign cnt_base = sof_i ? '0 : cnt_q;
  assign lt_base  = sof_i ? '0 : lt_q;
  assign op_base  = sof_i ? '0 : op_q;

  always_comb begin
    cnt_nxt = cnt_base;
    lt_nxt  = lt_base;
    op_nxt  = op_base;
    if (accept_o) begin
      if (cnt_base != CNT_W'(SAT)) cnt_nxt = cnt_base + 1'b1;
      for (int b = 0; b < int'(FB); b++) begin
        if (cnt_base == CNT_W'(LT_OFFSET + b))
          lt_nxt[FIELD_W-1-8*b -: 8] = data_i;
        if (cnt_base == CNT_W'(OP_OFF + b))
          op_nxt[FIELD_W-1-8*b -: 8] = data_i;
      end
    end
  end

  assign cnt_nxt_o = cnt_nxt;
  assign lt_nxt_o  = lt_nxt;
  assign op_nxt_o  = op_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      lt_q       <= '0;
      op_q       <= '0;
    end else begin
      if (done_o)        in_frame_q <= 1'b0;
      else if (accept_o) in_frame_q <= 1'b1;
      cnt_q <= cnt_nxt;
      lt_q  <= lt_nxt;
      op_q  <= op_nxt;
    end
  end
endmodule

// File: rtl/rfc_flag_decode.sv
module rfc_flag_decode
  import rfc_pkg::*;
#(
  parameter int unsigned LT_OFFSET  = 12,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned XB_W       = 3,
  parameter logic [FIELD_W-1:0] VLAN_ID   = 16'h8100,
  parameter logic [FIELD_W-1:0] CTRL_TYPE = 16'h8808,
  parameter logic [FIELD_W-1:0] PAUSE_OP  = 16'h0001
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [FIELD_W-1:0] lt_i,
  input  logic [FIELD_W-1:0] op_i,
  input  logic [XB_W-1:0]    extra_bits_i,
  input  logic [FIELD_W-1:0] max_len_i,
  output rfc_status_t        flags_o
);
  localparam int unsigned FB      = FIELD_W / 8;
  localparam int unsigned HDR_END = LT_OFFSET + FB;
  localparam int unsigned OP_END  = HDR_END + FB;

  logic hdr_ok, op_ok, is_ctrl, is_pause;

  assign hdr_ok   = cnt_i >= CNT_W'(HDR_END);
  assign op_ok    = cnt_i >= CNT_W'(OP_END);
  assign is_ctrl  = hdr_ok && (lt_i == CTRL_TYPE);
  assign is_pause = is_ctrl && op_ok && (op_i == PAUSE_OP);

  always_comb begin
    flags_o           = '0;
    flags_o.ctrl      = is_ctrl;
    flags_o.pause     = is_pause;
    flags_o.unsup_op  = is_ctrl && !is_pause;
    flags_o.vlan      = hdr_ok && (lt_i == VLAN_ID);
    flags_o.len_range = hdr_ok && (lt_i > max_len_i);  // status only, not a fault
    flags_o.dribble   = |extra_bits_i;
    flags_o.short_hdr = !hdr_ok;
  end
endmodule

// File: rtl/rfc_status_reg.sv
module rfc_status_reg
  import rfc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        open_i,
  input  logic        done_i,
  input  rfc_status_t flags_i,
  output rfc_status_t status_o,
  output logic        valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i)      status_o <= flags_i;
      else if (open_i) status_o <= '0;
    end
  end
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rfc_pkg::*;
#(
  parameter int unsigned LT_OFFSET = 12,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned XB_W      = 3,
  parameter logic [LEN_W-1:0] VLAN_ID   = 16'h8100,
  parameter logic [LEN_W-1:0] CTRL_TYPE = 16'h8808,
  parameter logic [LEN_W-1:0] PAUSE_OP  = 16'h0001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_valid_i,
  input  logic [7:0]          data_i,
  input  logic                sof_i,
  input  logic                eof_i,
  input  logic [XB_W-1:0]     extra_bits_i,
  input  logic [LEN_W-1:0]    max_len_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                status_valid_o
);
  localparam int unsigned FB    = LEN_W / 8;
  localparam int unsigned CNT_W = $clog2(LT_OFFSET + 2 * FB + 1);

  logic             accept, done;
  logic [CNT_W-1:0] cnt_nxt;
  logic [LEN_W-1:0] lt_nxt, op_nxt;
  rfc_status_t      flags, status_q;

  rfc_field_capture #(
    .LT_OFFSET (LT_OFFSET),
    .FIELD_W   (LEN_W),
    .CNT_W     (CNT_W)
  ) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_valid_i (data_valid_i),
    .data_i       (data_i),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .accept_o     (accept),
    .done_o       (done),
    .cnt_nxt_o    (cnt_nxt),
    .lt_nxt_o     (lt_nxt),
    .op_nxt_o     (op_nxt)
  );

  rfc_flag_decode #(
    .LT_OFFSET (LT_OFFSET),
    .FIELD_W   (LEN_W),
    .CNT_W     (CNT_W),
    .XB_W      (XB_W),
    .VLAN_ID   (VLAN_ID),
    .CTRL_TYPE (CTRL_TYPE),
    .PAUSE_OP  (PAUSE_OP)
  ) u_decode (
    .cnt_i        (cnt_nxt),
    .lt_i         (lt_nxt),
    .op_i         (op_nxt),
    .extra_bits_i (extra_bits_i),
    .max_len_i    (max_len_i),
    .flags_o      (flags)
  );

  rfc_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (accept & sof_i),
    .done_i   (done),
    .flags_i  (flags),
    .status_o (status_q),
    .valid_o  (status_valid_o)
  );

  assign status_o = status_q;
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int unsigned XB_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            data_valid_i,
  input logic            eof_i,
  input logic [XB_W-1:0] extra_bits_i,
  input logic [6:0]      status_o,
  input logic            status_valid_o
);
  assert_valid_after_eof_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> $past(data_valid_i && eof_i));

  assert_pause_needs_ctrl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && status_o[1]) |-> status_o[0]);

  assert_ctrl_opcode_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && status_o[0]) |-> ($countones(status_o[2:1]) == 1));

  assert_vlan_ctrl_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> $onehot0({status_o[3], status_o[0]}));

  assert_dribble_tracks_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> (status_o[5] == $past(|extra_bits_i)));

  assert_short_clears_hdr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_valid_o && status_o[6]) |-> (status_o[4:3] == 2'b00 && !status_o[0]));
endmodule

bind rx_frame_classifier rfc_checker #(.XB_W(XB_W)) u_rfc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .data_valid_i   (data_valid_i),
  .eof_i          (eof_i),
  .extra_bits_i   (extra_bits_i),
  .status_o       (status_o),
  .status_valid_o (status_valid_o)
);

// File: tb/tb_rx_frame_classifier.sv
module tb_rx_frame_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv = 1'b0;
  logic [7:0]  din = '0;
  logic        sof = 1'b0;
  logic        eof = 1'b0;
  logic [2:0]  xb = '0;
  logic [15:0] max_len = 16'd1536;
  logic [6:0]  st;
  logic        st_v;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] frm [64];

  always #5 clk = ~clk;

  rx_frame_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .data_valid_i(dv), .data_i(din),
    .sof_i(sof), .eof_i(eof), .extra_bits_i(xb), .max_len_i(max_len),
    .status_o(st), .status_valid_o(st_v)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_status(int len, int xbits, logic [15:0] mx);
    logic [15:0] lt, op;
    logic hdr, ctrl, pause;
    lt    = (len >= 14) ? {frm[12], frm[13]} : 16'h0;
    op    = (len >= 16) ? {frm[14], frm[15]} : 16'h0;
    hdr   = len >= 14;
    ctrl  = hdr && lt == 16'h8808;
    pause = ctrl && len >= 16 && op == 16'h0001;
    return {!hdr, xbits != 0, hdr && (lt > mx), hdr && lt == 16'h8100,
            ctrl && !pause, pause, ctrl};
  endfunction

  task automatic idle();
    dv = 0; sof = 0; eof = 0; xb = '0; din = '0;
  endtask

  // drives len bytes; closes the frame if close is set
  task automatic drive(int len, int xbits, bit close, bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      dv = 1; din = frm[i]; sof = (i == 0);
      eof = close && (i == len - 1);
      xb = eof ? 3'(xbits) : 3'd0;
      if (gaps && i != len - 1 && ($urandom % 4) == 0) begin
        @(negedge clk); idle();
      end
    end
    @(negedge clk); idle();
  endtask

  task automatic frame(string req, int len, int xbits, bit gaps);
    logic [6:0] e;
    e = exp_status(len, xbits, max_len);
    drive(len, xbits, 1'b1, gaps);
    chk({req, " valid"}, {31'd0, st_v}, 32'd1);
    chk({req, " status"}, {25'd0, st}, {25'd0, e});
    @(negedge clk);
    chk("R1 one-cycle strobe", {31'd0, st_v}, 32'd0);
  endtask

  task automatic fill(int len, logic [15:0] lt, logic [15:0] op);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    frm[12] = lt[15:8]; frm[13] = lt[7:0];
    frm[14] = op[15:8]; frm[15] = op[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lts [6];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, st_v}, 32'd0);
    chk("R1 reset status", {25'd0, st}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    fill(60, 16'h8100, 16'h1234); frame("R2 vlan", 60, 0, 0);
    fill(60, 16'h0800, 16'h4500); frame("R3 ip type range", 60, 0, 0);
    fill(60, 16'h0806, 16'h0001); frame("R3 arp type range", 60, 0, 1);
    // R4: same frame, range toggled by limit only
    fill(40, 16'h0030, 16'h0000); frame("R4 in range", 40, 0, 0);
    max_len = 16'h0020; frame("R4 out of range", 40, 0, 0);
    max_len = 16'h0030; frame("R3 equal limit", 40, 0, 0);
    max_len = 16'd1536;
    fill(60, 16'h8808, 16'h0001); frame("R5 R6 pause", 60, 0, 0);
    fill(60, 16'h8808, 16'h0002); frame("R7 unsupported", 60, 0, 0);
    fill(15, 16'h8808, 16'h0001); frame("R7 opcode cut short", 15, 0, 0);
    fill(16, 16'h8808, 16'h0001); frame("R6 minimal pause", 16, 0, 0);
    fill(30, 16'h0040, 16'h0000); frame("R8 dribble 7", 30, 7, 0);
    fill(30, 16'h0040, 16'h0000); frame("R8 dribble 1", 30, 1, 0);
    fill(13, 16'h8100, 16'h0000); frame("R9 short 13", 13, 0, 0);
    fill(1, 16'h0000, 16'h0000);  frame("R9 single byte", 1, 3, 0);
    fill(14, 16'h8100, 16'h0000); frame("R9 R2 exact header", 14, 0, 0);

    // R10: stray bytes with eof while no frame is open are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dv = 1; din = 8'($urandom); eof = 1; xb = 3'd5;
      @(negedge clk); idle();
      chk("R10 stray eof ignored", {31'd0, st_v}, 32'd0);
    end
    // R10: abandoned control frame, restarted by a plain one
    fill(20, 16'h8808, 16'h0001);
    drive(20, 0, 1'b0, 1'b0);
    chk("R10 no status for open frame", {31'd0, st_v}, 32'd0);
    fill(25, 16'h0010, 16'h0000); frame("R10 restart", 25, 0, 0);

    lts = '{16'h8100, 16'h8808, 16'h0800, 16'h0806, 16'h05dc, 16'h0000};
    for (int n = 0; n < 300; n++) begin
      logic [15:0] lt, op;
      int len;
      lt  = ($urandom % 7 == 6) ? 16'($urandom) : lts[$urandom % 6];
      if (($urandom % 6) == 0) lt = 16'($urandom % 1600);
      op  = ($urandom % 2) ? 16'h0001 : 16'($urandom % 4);
      len = 1 + ($urandom % 40);
      max_len = ($urandom % 3 == 0) ? 16'($urandom) : 16'd1536;
      fill(len, lt, op);
      frame("R2-R9 random", len, int'($urandom % 8), 1'b1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule